// File: doc/BRIEF.md
# IQ Gain and Phase Imbalance Corrector

This block removes amplitude and quadrature-phase mismatch between the in-phase and quadrature channels of a complex sample stream. Each valid I/Q pair is multiplied by a lower-triangular 2x2 matrix. The corrected I is the input I scaled by one plus a magnitude coefficient over 64. The corrected Q is the input Q plus the input I weighted by a phase coefficient over 64. Q is never scaled.

The two signed coefficients are written through a simple settings port: a write strobe, an address and a data word. The input stream is qualified by a valid flag. The output stream has the same width and carries a valid flag that stays aligned with its data. The arithmetic runs in a fixed two-stage pipeline. The first stage multiplies. The second stage rounds, adds and saturates. A build-time parameter turns the whole stage into a combinational wire.

Top module: `iq_imbal_corr`

## Requirements
- R1: Synchronous reset drives `out_valid` low, sets `out_i` and `out_q` to 0, and clears both coefficients to 0.
- R2: A write with `cfg_addr` equal to `MAG_ADDR` (default 0) loads coefficient A from `cfg_data`. A write with `cfg_addr` equal to `PHS_ADDR` (default 1) loads coefficient B. Both are signed values of `COEF_W` bits. A write to any other address changes neither coefficient. A new value applies to every sample presented on a later cycle.
- R3: The corrected I equals floor((64·I + A·I + 32) / 64). This is I·(1 + A/64) rounded to nearest, with exact halves rounded toward positive infinity.
- R4: The corrected Q equals Q + floor((B·I + 32) / 64). Q enters unscaled, and only the I-dependent term is rounded.
- R5: With A = 0 and B = 0, every sample passes through unchanged.
- R6: Each corrected output saturates to the range [−2^(DATA_W−1), 2^(DATA_W−1)−1], which is [−32768, 32767] by default. It never wraps.
- R7: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The data of each sample appears in the same cycle as its valid.
- R8: While `out_valid` is low, `out_i` and `out_q` hold the last corrected values.
- R9: With `BYPASS` = 1, `out_i`, `out_q` and `out_valid` equal `in_i`, `in_q` and `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_addr | input | ADDR_W | Settings register address |
| cfg_data | input | COEF_W | Signed coefficient value to write |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | DATA_W | Signed in-phase input |
| in_q | input | DATA_W | Signed quadrature input |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | DATA_W | Corrected in-phase output |
| out_q | output | DATA_W | Corrected quadrature output |

## Verification
The properties assume that the coefficient registers hold steady between a sample's arrival and the check on that sample. They also assume that reset is held from time zero until the first clock edges have passed. The stimulus follows both rules. Every coefficient write finishes at least one cycle before the sample that depends on it, and no write happens while a checked sample is in the pipeline. In the streaming pass, the coefficients stay fixed while samples arrive with gaps in `in_valid`, so the latency and hold properties see both levels of the valid flag.

// File: rtl/iqc_pkg.sv
package iqc_pkg;
    // Number of fraction bits in the coefficient scale (divide by 64)
    localparam int IQC_FRAC_SH = 6;

    // Settings register selected by a write
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAG  = 2'd1,
        SEL_PHS  = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/iqc_cfg_regs.sv
module iqc_cfg_regs
    import iqc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int COEF_W   = 18,
    parameter int MAG_ADDR = 0,
    parameter int PHS_ADDR = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic signed [COEF_W-1:0] data,
    output logic signed [COEF_W-1:0] mag,
    output logic signed [COEF_W-1:0] phs
);
    localparam logic [ADDR_W-1:0] MAG_A = ADDR_W'(MAG_ADDR);
    localparam logic [ADDR_W-1:0] PHS_A = ADDR_W'(PHS_ADDR);

    cfg_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (wr) begin
            if (addr == MAG_A)      sel = SEL_MAG;
            else if (addr == PHS_A) sel = SEL_PHS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag <= '0;
            phs <= '0;
        end else begin
            unique case (sel)
                SEL_MAG:  mag <= data;
                SEL_PHS:  phs <= data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/iqc_sat.sv
module iqc_sat #(
    parameter int IN_W  = 36,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] HI = IN_W'({1'b0, {(OUT_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

    always_comb begin
        if (din > HI)      dout = HI[OUT_W-1:0];
        else if (din < LO) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/iqc_lane.sv
module iqc_lane #(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 18,
    parameter int FRAC_SH = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_mul,
    input  logic                     en_sum,
    input  logic signed [DATA_W-1:0] mul_x,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] addend,
    output logic signed [DATA_W-1:0] result
);
    localparam int PW = DATA_W + COEF_W;
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] BIAS = SW'(1) <<< (FRAC_SH - 1);

    logic signed [PW-1:0]     prod_q;
    logic signed [DATA_W-1:0] add_q;
    logic signed [SW-1:0]     biased, scaled, total;
    logic signed [DATA_W-1:0] clipped;

    // Stage 1: full-precision product, addend aligned alongside
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            add_q  <= '0;
        end else if (en_mul) begin
            prod_q <= PW'(mul_x) * PW'(coef);
            add_q  <= addend;
        end
    end

    // Stage 2: round to nearest, scale, accumulate, clip
    always_comb begin
        biased = SW'(prod_q) + BIAS;
        scaled = biased >>> FRAC_SH;
        total  = scaled + SW'(add_q);
    end

    iqc_sat #(.IN_W(SW), .OUT_W(DATA_W)) u_sat (
        .din  (total),
        .dout (clipped)
    );

    always_ff @(posedge clk) begin
        if (rst)         result <= '0;
        else if (en_sum) result <= clipped;
    end
endmodule

// File: rtl/iq_imbal_corr.sv
module iq_imbal_corr
    import iqc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 18,
    parameter int ADDR_W   = 8,
    parameter int MAG_ADDR = 0,
    parameter int PHS_ADDR = 1,
    parameter bit BYPASS   = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic signed [COEF_W-1:0] cfg_data,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    logic signed [COEF_W-1:0] mag_coef;
    logic signed [COEF_W-1:0] phs_coef;

    iqc_cfg_regs #(
        .ADDR_W  (ADDR_W),
        .COEF_W  (COEF_W),
        .MAG_ADDR(MAG_ADDR),
        .PHS_ADDR(PHS_ADDR)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .wr   (cfg_wr),
        .addr (cfg_addr),
        .data (cfg_data),
        .mag  (mag_coef),
        .phs  (phs_coef)
    );

    generate
        if (BYPASS) begin : g_wire
            assign out_valid = in_valid;
            assign out_i     = in_i;
            assign out_q     = in_q;
        end else begin : g_corr
            logic vld_s1, vld_s2;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_s1 <= 1'b0;
                    vld_s2 <= 1'b0;
                end else begin
                    vld_s1 <= in_valid;
                    vld_s2 <= vld_s1;
                end
            end

            // I lane: I + I*A/64
            iqc_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_SH(IQC_FRAC_SH)) u_lane_i (
                .clk    (clk),
                .rst    (rst),
                .en_mul (in_valid),
                .en_sum (vld_s1),
                .mul_x  (in_i),
                .coef   (mag_coef),
                .addend (in_i),
                .result (out_i)
            );

            // Q lane: Q + I*B/64
            iqc_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_SH(IQC_FRAC_SH)) u_lane_q (
                .clk    (clk),
                .rst    (rst),
                .en_mul (in_valid),
                .en_sum (vld_s1),
                .mul_x  (in_i),
                .coef   (phs_coef),
                .addend (in_q),
                .result (out_q)
            );

            assign out_valid = vld_s2;
        end
    endgenerate
endmodule

// File: rtl/iq_imbal_corr_chk.sv
module iq_imbal_corr_chk #(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 18,
    parameter int ADDR_W   = 8,
    parameter int MAG_ADDR = 0,
    parameter int PHS_ADDR = 1,
    parameter bit BYPASS   = 1'b0
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_wr,
    input logic [ADDR_W-1:0]        cfg_addr,
    input logic signed [COEF_W-1:0] cfg_data,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_i,
    input logic signed [DATA_W-1:0] in_q,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q,
    input logic signed [COEF_W-1:0] mag_coef,
    input logic signed [COEF_W-1:0] phs_coef
);
    localparam logic [ADDR_W-1:0] MAG_A = ADDR_W'(MAG_ADDR);
    localparam logic [ADDR_W-1:0] PHS_A = ADDR_W'(PHS_ADDR);

    generate
        if (!BYPASS) begin : g_props
            a_r2_mag_load: assert property (@(posedge clk) disable iff (rst)
                (cfg_wr && cfg_addr == MAG_A) |=> (mag_coef == $past(cfg_data)));

            a_r2_phs_load: assert property (@(posedge clk) disable iff (rst)
                (cfg_wr && cfg_addr == PHS_A && cfg_addr != MAG_A) |=> (phs_coef == $past(cfg_data)));

            a_r2_no_stray_write: assert property (@(posedge clk) disable iff (rst)
                !(cfg_wr && (cfg_addr == MAG_A || cfg_addr == PHS_A))
                |=> ($stable(mag_coef) && $stable(phs_coef)));

            a_r5_identity: assert property (@(posedge clk) disable iff (rst)
                (in_valid && mag_coef == '0 && phs_coef == '0)
                |-> ##2 (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

            a_r4_q_unscaled: assert property (@(posedge clk) disable iff (rst)
                (in_valid && phs_coef == '0) |-> ##2 (out_q == $past(in_q, 2)));

            a_r7_valid_fwd: assert property (@(posedge clk) disable iff (rst)
                in_valid |-> ##2 out_valid);

            a_r7_valid_quiet: assert property (@(posedge clk) disable iff (rst)
                !in_valid |-> ##2 !out_valid);

            a_r8_hold: assert property (@(posedge clk) disable iff (rst)
                !out_valid |-> ($stable(out_i) && $stable(out_q)));
        end
    endgenerate
endmodule

bind iq_imbal_corr iq_imbal_corr_chk #(
    .DATA_W  (DATA_W),
    .COEF_W  (COEF_W),
    .ADDR_W  (ADDR_W),
    .MAG_ADDR(MAG_ADDR),
    .PHS_ADDR(PHS_ADDR),
    .BYPASS  (BYPASS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .out_valid(out_valid),
    .out_i    (out_i),
    .out_q    (out_q),
    .mag_coef (mag_coef),
    .phs_coef (phs_coef)
);

// File: tb/test_iq_imbal_corr.sv
`timescale 1ns/1ps
module test_iq_imbal_corr;
    localparam int DATA_W = 16;
    localparam int COEF_W = 18;
    localparam int ADDR_W = 8;
    localparam time TCLK  = 20ns;

    // columns: A, B, I, Q, expected I', expected Q'
    localparam int NV = 14;
    localparam int VEC [0:NV-1][0:5] = '{
        '{0,      0,    1000,   -2000, 1000,   -2000},  // R5
        '{64,     0,    1000,   5,     2000,   5},      // R3
        '{-32,    0,    1001,   0,     501,    0},      // R3 half up
        '{0,      64,   300,    -100,  300,    200},    // R4
        '{0,      -16,  100,    10,    100,    -15},    // R4
        '{0,      1,    32,     0,     32,     1},      // R4 half toward +inf
        '{0,      1,    -32,    0,     -32,    0},      // R4 half toward +inf
        '{0,      1,    31,     0,     31,     0},      // R4 below half
        '{64,     0,    20000,  0,     32767,  0},      // R6
        '{64,     0,    -20000, 0,     -32768, 0},      // R6
        '{0,      64,   30000,  10000, 30000,  32767},  // R6
        '{0,      -64,  30000,  -10000,30000,  -32768}, // R6
        '{-64,    0,    -32768, 0,     0,      0},      // R3
        '{131071, 0,    1,      0,     2049,   0}       // R3 max coefficient
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic signed [COEF_W-1:0] cfg_data = '0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_i = '0;
    logic signed [DATA_W-1:0] in_q = '0;
    logic out_valid, byp_valid;
    logic signed [DATA_W-1:0] out_i, out_q, byp_i, byp_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    iq_imbal_corr #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) i_iq_imbal_corr (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    iq_imbal_corr #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ADDR_W(ADDR_W), .BYPASS(1'b1)) i_iq_imbal_corr_byp (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(byp_valid), .out_i(byp_i), .out_q(byp_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; leaves at a negedge with cfg_wr low
    task automatic set_coefs(input int a, input int b);
        cfg_wr = 1'b1; cfg_addr = 8'd0; cfg_data = COEF_W'(a);
        @(negedge clk);
        cfg_addr = 8'd1; cfg_data = COEF_W'(b);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // one sample, checked two edges later
    task automatic one_sample(input int i, input int q, input int ei, input int eq, input string tag);
        in_valid = 1'b1; in_i = DATA_W'(i); in_q = DATA_W'(q);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " I"}, int'(out_i), ei);
        chk({tag, " Q"}, int'(out_q), eq);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset I", int'(out_i), 0);
        chk("R1 reset Q", int'(out_q), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5: coefficients cleared by reset, sample passes unchanged
        one_sample(-1234, 4321, -1234, 4321, "R5 after reset");

        // table walk: R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            set_coefs(VEC[k][0], VEC[k][1]);
            one_sample(VEC[k][2], VEC[k][3], VEC[k][4], VEC[k][5], $sformatf("R3/R4/R6 row%0d", k));
        end

        // R2: a write to an unmapped address is ignored
        set_coefs(0, 0);
        cfg_wr = 1'b1; cfg_addr = 8'd5; cfg_data = 18'sd64;
        @(negedge clk);
        cfg_wr = 1'b0;
        one_sample(123, 45, 123, 45, "R2 stray address");

        // R2: the mag register alone changes I but not Q weighting
        cfg_wr = 1'b1; cfg_addr = 8'd0; cfg_data = 18'sd64;
        @(negedge clk);
        cfg_wr = 1'b0;
        one_sample(100, 7, 200, 7, "R2 mag write");

        // R7 R8: streaming with gaps, A=0, B=32
        set_coefs(0, 32);
        begin
            bit vpat [0:9] = '{1, 1, 0, 1, 1, 1, 0, 0, 0, 0};
            int hi [0:9];
            int hq [0:9];
            int last_i = 200;
            int last_q = 7;
            for (int t = 0; t < 10; t++) begin
                hi[t] = 100 * (t + 1);
                hq[t] = -7 * t;
            end
            for (int t = 0; t < 10; t++) begin
                if (t >= 2) begin
                    chk($sformatf("R7 valid t%0d", t), int'(out_valid), int'(vpat[t-2]));
                    if (vpat[t-2]) begin
                        last_i = hi[t-2];
                        last_q = hq[t-2] + hi[t-2] / 2;
                    end
                    chk($sformatf("R8 I t%0d", t), int'(out_i), last_i);
                    chk($sformatf("R8 Q t%0d", t), int'(out_q), last_q);
                end
                in_valid = vpat[t];
                in_i = DATA_W'(hi[t]);
                in_q = DATA_W'(hq[t]);
                @(negedge clk);
            end
            in_valid = 1'b0;
        end

        // R9: bypass build is a wire
        in_valid = 1'b1; in_i = -16'sd5; in_q = 16'sd9;
        #1;
        chk("R9 bypass valid", int'(byp_valid), 1);
        chk("R9 bypass I", int'(byp_i), -5);
        chk("R9 bypass Q", int'(byp_q), 9);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);

        // R1: mid-run reset clears coefficients
        set_coefs(64, 64);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid reset valid", int'(out_valid), 0);
        chk("R1 mid reset I", int'(out_i), 0);
        rst = 1'b0;
        @(negedge clk);
        one_sample(10, 3, 10, 3, "R1 coefs cleared");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule